// File: doc/BRIEF.md
# Windowed Address Translator with High-Bit Substitution

This block sits on the path from a 32-bit local bus into a remote bus. It holds up to six address windows. Each window is a base and a high address, fixed at build time. For every incoming local address the block reports whether a window claims it, which window that is, and the window's space type (I/O or memory). It also produces the remote address.

The remote address is not formed by adding an offset. Each window has an aligned size. The block keeps the address bits that lie below that size and replaces every bit above it with that window's translation bits. The replaced bits are the ones where the base and the high address agree, working down from the most significant bit. A build option picks where the translation bits come from. With the option off, they are fixed by parameters. With it on, they sit in registers that a simple indexed write port can change at runtime; those registers start from the parameter values after reset.

The lookup is combinational from address to result. A parameter can add one output register stage when timing needs it.

Top module: `addr_window_xlate`

## Requirements
- R1: Only windows 0 to NWIN-1 are active, with NWIN from 1 to 6. An address that falls only inside the range of a window numbered NWIN or higher gives a miss.
- R2: Window w hits when base_w <= addr and addr <= high_w, unsigned, with both ends included. An address one below the base or one above the high does not hit that window.
- R3: When several windows hit, `hit_idx_o` reports the lowest-numbered one, as a 3-bit binary index.
- R4: On a hit, take the bits of the address from the MSB downward while base_w and high_w agree. Those bits are replaced by the same bits of the window's translation value. Every lower bit passes from `addr_i` unchanged. For example, 0x12340000..0x1234FFFF replaces bits 31..16, and 0xABCDE000..0xABCDFFFF replaces bits 31..13.
- R5: On a hit, `hit_space_o` is bit w of the SPACE parameter, where 0 means I/O space and 1 means memory space.
- R6: On a miss, `hit_o`=0, `hit_idx_o`=0, `hit_space_o`=0, and `xaddr_o` equals `addr_i`.
- R7: With USE_REGS=1, a cycle with `wr_en_i`=1 and `wr_idx_i`<NWIN loads `wr_data_i` into that window's translation register. The new value is used from the next cycle. A write with `wr_idx_i`>=NWIN changes no window.
- R8: With USE_REGS=1, reset (synchronous, `rst_n`=0) returns every translation register to its XL_INIT value.
- R9: With USE_REGS=0, the write port has no effect and the XL_INIT values are always used.
- R10: With REG_OUT=1, all four outputs appear one clock after the address is sampled. During reset all of them are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | AW | Local address to translate |
| wr_en_i | input | 1 | Translation register write strobe |
| wr_idx_i | input | 3 | Window index of the write |
| wr_data_i | input | AW | New translation value |
| hit_o | output | 1 | A window claims the address |
| hit_idx_o | output | 3 | Index of the claiming window |
| hit_space_o | output | 1 | Space type of the claiming window (0 I/O, 1 memory) |
| xaddr_o | output | AW | Remote address |

## Verification
On every cycle, the assertions check the combinational lookup:
- the reported window really matched and no lower-numbered window matched;
- below the selected window's mask, the remote address equals the local address;
- a miss means no window matched and the address passes through;
- with the output register present, the outputs trail the lookup by exactly one cycle.

Other behaviours can only be shown by the bench's scenarios, because they depend on the parameter tables and on the history of writes. These are:
- the exact substituted high bits;
- the inclusive window edges;
- inactive windows being ignored;
- writes taking effect or being ignored;
- reset restoring the translation values.

// File: rtl/xlate_pkg.sv
// Shared constants and types for the windowed address translator.
// Assumes at most six windows, so a window index fits in three bits.
package xlate_pkg;
    localparam int MAX_WIN = 6;
    localparam int IDX_W   = 3;
    typedef logic [IDX_W-1:0] win_idx_t;
endpackage

// File: rtl/xw_match.sv
// One window comparator. It flags an inclusive range hit and exports the
// constant substitution mask: high bits where base and high agree.
// Assumes BASE <= HIGH.
module xw_match #(
    parameter int            AW   = 32,
    parameter logic [AW-1:0] BASE = '0,
    parameter logic [AW-1:0] HIGH = '1
) (
    input  logic [AW-1:0] addr_i,
    output logic          hit_o,
    output logic [AW-1:0] mask_o
);
    // Walk from the MSB and keep bits while base and high still agree
    function automatic logic [AW-1:0] calc_mask(input logic [AW-1:0] b, input logic [AW-1:0] h);
        logic [AW-1:0] m;
        logic          same;
        same = 1'b1;
        for (int i = AW - 1; i >= 0; i--) begin
            same = same & (b[i] == h[i]);
            m[i] = same;
        end
        return m;
    endfunction

    localparam logic [AW-1:0] SUB_MASK = calc_mask(BASE, HIGH);

    // Inclusive unsigned range compare
    assign hit_o  = (addr_i >= BASE) && (addr_i <= HIGH);
    assign mask_o = SUB_MASK;
endmodule

// File: rtl/xw_xlate_bank.sv
// Source of the per-window translation values. When USE_REGS is set it is
// a register bank with an indexed write port that resets to INIT. Otherwise
// it is the INIT constants and the write port is ignored.
module xw_xlate_bank
    import xlate_pkg::*;
#(
    parameter int                      AW       = 32,
    parameter int                      NWIN     = 6,
    parameter bit                      USE_REGS = 1'b1,
    parameter logic [MAX_WIN*AW-1:0]   INIT     = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  win_idx_t           wr_idx_i,
    input  logic [AW-1:0]      wr_data_i,
    output logic [NWIN*AW-1:0] xl_flat_o
);
    generate
        if (USE_REGS) begin : g_regs
            logic [AW-1:0] xl_q [NWIN];

            // Load INIT on reset; afterwards accept writes to in-range indices
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < NWIN; i++) xl_q[i] <= INIT[i*AW +: AW];
                end else if (wr_en_i) begin
                    for (int i = 0; i < NWIN; i++)
                        if (wr_idx_i == win_idx_t'(i)) xl_q[i] <= wr_data_i;
                end
            end

            for (genvar w = 0; w < NWIN; w++) begin : g_flat
                assign xl_flat_o[w*AW +: AW] = xl_q[w];
            end
        end else begin : g_const
            logic unused_wr;
            assign unused_wr = ^{clk, rst_n, wr_en_i, wr_idx_i, wr_data_i};
            assign xl_flat_o = INIT[NWIN*AW-1:0];
        end
    endgenerate
endmodule

// File: rtl/xw_select.sv
// Priority selector. It picks the lowest-numbered hitting window and merges
// that window's translation bits above its mask with the untouched low
// bits. On a miss the address passes through.
module xw_select
    import xlate_pkg::*;
#(
    parameter int                 AW    = 32,
    parameter int                 NWIN  = 6,
    parameter logic [MAX_WIN-1:0] SPACE = '0
) (
    input  logic [AW-1:0]      addr_i,
    input  logic [NWIN-1:0]    win_hit_i,
    input  logic [NWIN*AW-1:0] mask_flat_i,
    input  logic [NWIN*AW-1:0] xl_flat_i,
    output logic               hit_o,
    output win_idx_t           idx_o,
    output logic               space_o,
    output logic [AW-1:0]      mask_o,
    output logic [AW-1:0]      xaddr_o
);
    logic [AW-1:0] sel_xl;

    // Scan from the top index down so the lowest hit is applied last
    always_comb begin
        hit_o   = 1'b0;
        idx_o   = '0;
        space_o = 1'b0;
        mask_o  = '0;
        sel_xl  = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (win_hit_i[w]) begin
                hit_o   = 1'b1;
                idx_o   = win_idx_t'(w);
                space_o = SPACE[w];
                mask_o  = mask_flat_i[w*AW +: AW];
                sel_xl  = xl_flat_i[w*AW +: AW];
            end
        end
    end

    // Substitute the high bits on a hit, pass the address through on a miss
    assign xaddr_o = hit_o ? ((sel_xl & mask_o) | (addr_i & ~mask_o)) : addr_i;
endmodule

// File: rtl/addr_window_xlate.sv
// Windowed address translator, top level. It instantiates one comparator per
// active window, the translation value source, the priority selector, and an
// optional output register. Assumes 1 <= NWIN <= 6 and base <= high.
module addr_window_xlate
    import xlate_pkg::*;
#(
    parameter int                    AW       = 32,
    parameter int                    NWIN     = 6,
    parameter bit                    USE_REGS = 1'b1,
    parameter bit                    REG_OUT  = 1'b0,
    parameter logic [MAX_WIN*AW-1:0] WIN_BASE = {32'hC000_0000, 32'h0000_1000, 32'h8000_0000,
                                                 32'h1234_0000, 32'hABCD_E000, 32'h1234_0000},
    parameter logic [MAX_WIN*AW-1:0] WIN_HIGH = {32'hC000_03FF, 32'h0000_1FFF, 32'h8FFF_FFFF,
                                                 32'h1234_00FF, 32'hABCD_FFFF, 32'h1234_FFFF},
    parameter logic [MAX_WIN*AW-1:0] XL_INIT  = {32'h0A00_0000, 32'h7777_0000, 32'h3000_0000,
                                                 32'h9999_0000, 32'hFEDC_0000, 32'h5671_0000},
    parameter logic [MAX_WIN-1:0]    SPACE    = 6'b011001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [2:0]    wr_idx_i,
    input  logic [AW-1:0] wr_data_i,
    output logic          hit_o,
    output logic [2:0]    hit_idx_o,
    output logic          hit_space_o,
    output logic [AW-1:0] xaddr_o
);
    logic [NWIN-1:0]    win_hit;
    logic [NWIN*AW-1:0] mask_flat;
    logic [NWIN*AW-1:0] xl_flat;
    logic               c_hit;
    win_idx_t           c_idx;
    logic               c_space;
    logic [AW-1:0]      c_mask;
    logic [AW-1:0]      c_xaddr;

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            xw_match #(
                .AW   (AW),
                .BASE (WIN_BASE[w*AW +: AW]),
                .HIGH (WIN_HIGH[w*AW +: AW])
            ) u_match (
                .addr_i (addr_i),
                .hit_o  (win_hit[w]),
                .mask_o (mask_flat[w*AW +: AW])
            );
        end
    endgenerate

    xw_xlate_bank #(
        .AW       (AW),
        .NWIN     (NWIN),
        .USE_REGS (USE_REGS),
        .INIT     (XL_INIT)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_data_i (wr_data_i),
        .xl_flat_o (xl_flat)
    );

    xw_select #(
        .AW    (AW),
        .NWIN  (NWIN),
        .SPACE (SPACE)
    ) u_sel (
        .addr_i      (addr_i),
        .win_hit_i   (win_hit),
        .mask_flat_i (mask_flat),
        .xl_flat_i   (xl_flat),
        .hit_o       (c_hit),
        .idx_o       (c_idx),
        .space_o     (c_space),
        .mask_o      (c_mask),
        .xaddr_o     (c_xaddr)
    );

    generate
        if (REG_OUT) begin : g_oreg
            // Register the lookup result; clear it during reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hit_o       <= 1'b0;
                    hit_idx_o   <= '0;
                    hit_space_o <= 1'b0;
                    xaddr_o     <= '0;
                end else begin
                    hit_o       <= c_hit;
                    hit_idx_o   <= c_idx;
                    hit_space_o <= c_space;
                    xaddr_o     <= c_xaddr;
                end
            end
        end else begin : g_ocomb
            assign hit_o       = c_hit;
            assign hit_idx_o   = c_idx;
            assign hit_space_o = c_space;
            assign xaddr_o     = c_xaddr;
        end
    endgenerate
endmodule

// File: rtl/xw_checker.sv
// Assertion checker for addr_window_xlate, attached by bind. It watches the
// comparator outputs, the selector result and the top-level outputs.
module xw_checker
    import xlate_pkg::*;
#(
    parameter int AW      = 32,
    parameter int NWIN    = 6,
    parameter bit REG_OUT = 1'b0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   addr_i,
    input logic [NWIN-1:0] win_hit,
    input logic            c_hit,
    input win_idx_t        c_idx,
    input logic [AW-1:0]   c_mask,
    input logic [AW-1:0]   c_xaddr,
    input logic            hit_o,
    input logic [AW-1:0]   xaddr_o
);
    logic [NWIN-1:0] below;
    logic [NWIN-1:0] chosen;
    logic            past_ok;

    // Decode which windows lie below, and which equal, the reported index
    always_comb begin
        for (int i = 0; i < NWIN; i++) begin
            below[i]  = win_idx_t'(i) < c_idx;
            chosen[i] = win_idx_t'(i) == c_idx;
        end
    end

    // Mark that one full post-reset cycle has passed
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_IDX_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        c_hit |-> (int'(c_idx) < NWIN)); // R1

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        c_hit |-> (((win_hit & chosen) != '0) && ((win_hit & below) == '0))); // R3

    AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        c_hit |-> (((c_xaddr ^ addr_i) & ~c_mask) == '0)); // R4

    AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !c_hit |-> ((win_hit == '0) && (c_xaddr == addr_i))); // R6

    generate
        if (REG_OUT) begin : g_reg
            AST_ONE_CYCLE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
                past_ok |-> ((hit_o == $past(c_hit)) && (xaddr_o == $past(c_xaddr)))); // R10
        end else begin : g_comb
            AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                (hit_o == c_hit) && (xaddr_o == c_xaddr)); // R10
        end
    endgenerate
endmodule

bind addr_window_xlate xw_checker #(
    .AW      (AW),
    .NWIN    (NWIN),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .win_hit (win_hit),
    .c_hit   (c_hit),
    .c_idx   (c_idx),
    .c_mask  (c_mask),
    .c_xaddr (c_xaddr),
    .hit_o   (hit_o),
    .xaddr_o (xaddr_o)
);

// File: tb/sim_addr_window_xlate.sv
// Bench: u0 uses six windows, writable translation values and a
// combinational output. u1 uses four windows, fixed values and a
// registered output. Expected results come from an arithmetic model
// built on the bench's own window table.
module sim_addr_window_xlate;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;

    logic        h0, s0, h1, s1;
    logic [2:0]  i0, i1;
    logic [31:0] x0, x1;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] tb_base [6] = '{32'h1234_0000, 32'hABCD_E000, 32'h1234_0000,
                                 32'h8000_0000, 32'h0000_1000, 32'hC000_0000};
    logic [31:0] tb_high [6] = '{32'h1234_FFFF, 32'hABCD_FFFF, 32'h1234_00FF,
                                 32'h8FFF_FFFF, 32'h0000_1FFF, 32'hC000_03FF};
    logic [31:0] tb_init [6] = '{32'h5671_0000, 32'hFEDC_0000, 32'h9999_0000,
                                 32'h3000_0000, 32'h7777_0000, 32'h0A00_0000};
    logic        tb_sp   [6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    logic [31:0] tb_xl   [6];

    always #(CLK_P/2) clk = ~clk;

    addr_window_xlate #(.NWIN(6), .USE_REGS(1'b1), .REG_OUT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .hit_o(h0), .hit_idx_o(i0), .hit_space_o(s0), .xaddr_o(x0));

    addr_window_xlate #(.NWIN(4), .USE_REGS(1'b0), .REG_OUT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .hit_o(h1), .hit_idx_o(i1), .hit_space_o(s1), .xaddr_o(x1));

    // Mask from the position of the highest bit where base and high differ
    function automatic logic [31:0] exp_mask(input logic [31:0] b, input logic [31:0] h);
        logic [31:0] d;
        logic [32:0] t;
        int          p;
        d = b ^ h;
        p = -1;
        for (int i = 0; i < 32; i++) if (d[i]) p = i;
        t = (33'h1 << (p + 1)) - 33'h1;
        return ~t[31:0];
    endfunction

    // Returns {hit, idx[2:0], space, xaddr[31:0]}
    function automatic logic [36:0] model(input logic [31:0] a, input int nw, input bit fixed);
        logic [36:0] r;
        logic [31:0] m;
        logic [31:0] xv;
        r = {1'b0, 3'd0, 1'b0, a};
        for (int w = nw - 1; w >= 0; w--) begin
            if (a >= tb_base[w] && a <= tb_high[w]) begin
                m  = exp_mask(tb_base[w], tb_high[w]);
                xv = fixed ? tb_init[w] : tb_xl[w];
                r  = {1'b1, w[2:0], tb_sp[w], (xv & m) | (a & ~m)};
            end
        end
        return r;
    endfunction

    task automatic check(input logic [36:0] act, input logic [36:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
        end
    endtask

    // Drive one address, check u0 mid-cycle and u1 after the next edge
    task automatic apply(input logic [31:0] a, input string tag0, input string tag1);
        @(negedge clk);
        addr = a;
        #1;
        check({h0, i0, s0, x0}, model(a, 6, 1'b0), tag0);
        @(posedge clk);
        #1;
        check({h1, i1, s1, x1}, model(a, 4, 1'b1), tag1);
    endtask

    task automatic write_xl(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (int'(idx) < 6) tb_xl[idx] = d;
    endtask

    task automatic edges(input string tag);
        for (int w = 0; w < 6; w++) begin
            apply(tb_base[w] - 32'd1, "R2", "R1");
            apply(tb_base[w], tag, "R1");
            apply(tb_base[w] + 32'd1, tag, "R10");
            apply(tb_high[w], tag, "R1");
            apply(tb_high[w] + 32'd1, "R2", "R10");
            apply(tb_base[w] + ((tb_high[w] - tb_base[w]) >> 1), "R5", "R1");
        end
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] lf;
        for (int i = 0; i < 6; i++) tb_xl[i] = tb_init[i];
        repeat (3) @(posedge clk);
        #1;
        check({h1, i1, s1, x1}, 37'd0, "R10 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Edges and midpoints of every window (R2, R4, R5, R1 for u1)
        edges("R4");
        // Overlap: window 2 lies inside window 0 (R3)
        apply(32'h1234_0000, "R3", "R3");
        apply(32'h1234_0080, "R3", "R3");
        apply(32'h1234_00FF, "R3", "R3");
        // Misses pass through (R6)
        apply(32'h0000_0000, "R6", "R6");
        apply(32'hFFFF_FFFF, "R6", "R6");
        apply(32'h5000_1234, "R6", "R6");
        // Dense sweep around window 1 covering its low 13 bits (R4)
        for (int k = 0; k < 4096; k++) apply(32'hABCD_D000 + 32'(k) * 32'd4, "R4", "R4");
        // Pseudo-random addresses, half biased into windows (R2, R4, R5)
        lf = 32'hACE1_2345;
        for (int k = 0; k < 3000; k++) begin
            int w;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            w = int'(lf[31:29] % 3'd6);
            if (lf[28]) apply(tb_base[w] + (lf % (tb_high[w] - tb_base[w] + 32'd1)), "R4", "R5");
            else        apply(lf, "R2", "R6");
        end

        // Runtime writes (R7), u1 ignores them (R9)
        write_xl(3'd1, 32'h1357_2468);
        write_xl(3'd0, 32'hDEAD_BEEF);
        write_xl(3'd5, 32'h0000_0000);
        edges("R7");
        write_xl(3'd6, 32'hFFFF_FFFF);
        write_xl(3'd7, 32'h1111_1111);
        edges("R7");
        apply(32'hABCD_F00D, "R7", "R9");

        // Reset restores initial values (R8)
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check({h1, i1, s1, x1}, 37'd0, "R10 reset");
        for (int i = 0; i < 6; i++) tb_xl[i] = tb_init[i];
        @(negedge clk);
        rst_n = 1'b1;
        edges("R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule